// File: doc/BRIEF.md
# Wide-Memory to Narrow-Bus Read Adapter

This block sits between a 32-bit AHB-style read path and a synchronous memory whose words are 64 bits wide. Each access carries a byte address. The block drops the three lowest address bits and sends the result to the memory as the word index. In the data phase it returns one 32-bit half of the word that comes back.

Address bit 2 picks the half. The block captures that bit in a register during the address phase and applies it one cycle later, when the memory's read data arrives. Two accesses that step through addresses 0 and 4 therefore read the same memory word and differ only in the half they return.

The adapter never stalls the bus and never signals an error. It handles reads only.

Top module: `wide_rd_adapter`

## Requirements
- R1: During a valid transfer, `mem_addr` equals `haddr[AW-1:3]`. Byte addresses 8n to 8n+7 all select memory word n.
- R2: `mem_rd` is high only when all three of these hold: `hsel` is 1, `hready` is 1, and `htrans` is NONSEQ (2'b10) or SEQ (2'b11). When they all hold, `mem_rd` is high in that same cycle.
- R3: When a transfer has `haddr[2]` = 0, `hrdata` equals `mem_rdata[31:0]` in the cycle after the transfer.
- R4: When a transfer has `haddr[2]` = 1, `hrdata` equals `mem_rdata[63:32]` in the cycle after the transfer.
- R5: Reads issued on consecutive cycles, with the address stepping by 4, return this sequence: the low half of word n, then the high half of word n, then the low half of word n+1.
- R6: IDLE (2'b00) and BUSY (2'b01) transfers issue no memory read. They also leave the selected half unchanged, so `hrdata` keeps its value.
- R7: An access with `hsel` at 0, or with `hready` at 0, issues no memory read and leaves the selected half unchanged.
- R8: `hreadyout` is always 1 and `hresp` is always 0 (OKAY).
- R9: After reset the selected half is the low one, so `hrdata` shows `mem_rdata[31:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Selects this block for the current transfer |
| haddr | input | AW | Byte address |
| htrans | input | 2 | Transfer type |
| hready | input | 1 | Bus ready; the address phase is accepted when this is high |
| hrdata | output | 32 | Read data for the data phase |
| hreadyout | output | 1 | Ready from this block; always high |
| hresp | output | 1 | Response; always OKAY (0) |
| mem_addr | output | AW-3 | Memory word index |
| mem_rd | output | 1 | Memory read enable |
| mem_rdata | input | 64 | Memory read data, valid one cycle after `mem_rd` |

## Verification
The bench builds the block with AW = 8. This gives 32 memory words and 256 byte addresses, so it can sweep every byte address and every word-aligned step of 4 through the whole memory. The memory model fills each word with values computed from its index, so the expected `hrdata` for any address is the address divided by 4 plus a constant. With the small address width, every word index and both halves of every word are reached. It also makes room for direct tests of each non-transfer case between reads.

// File: rtl/wide_rd_adapter.sv
module wide_rd_adapter #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hsel,
  input  logic [AW-1:0] haddr,
  input  logic [1:0]    htrans,
  input  logic          hready,
  output logic [31:0]   hrdata,
  output logic          hreadyout,
  output logic          hresp,
  output logic [AW-4:0] mem_addr,
  output logic          mem_rd,
  input  logic [63:0]   mem_rdata
);

  localparam int IW = AW - 3;

  logic take;
  logic hi_q;

  assign take      = hsel && hready && htrans[1];
  assign mem_rd    = take;
  assign mem_addr  = haddr[AW-1:3];
  assign hreadyout = 1'b1;
  assign hresp     = 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    hi_q <= 1'b0;
    else if (take) hi_q <= haddr[2];

  assign hrdata = hi_q ? mem_rdata[63:32] : mem_rdata[31:0];

  assert_index_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (({mem_addr, 3'b000} | {{IW{1'b0}}, haddr[2:0]}) == haddr));

  assert_no_read_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!htrans[1] || !hsel || !hready) |-> !mem_rd);

  assert_lane_mux_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> (hrdata == ($past(haddr[2]) ? mem_rdata[63:32] : mem_rdata[31:0])));

  assert_lane_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_rd ##1 $stable(mem_rdata)) |-> $stable(hrdata));

endmodule

// File: tb/tb_wide_rd_adapter.sv
module tb_wide_rd_adapter;
  localparam int AW = 8;
  localparam int NW = 1 << (AW - 3);

  logic clk = 0, rst_n = 0, hsel = 0, hready = 1;
  logic [AW-1:0] haddr = '0;
  logic [1:0] htrans = 2'b00;
  logic [31:0] hrdata;
  logic hreadyout, hresp, mem_rd;
  logic [AW-4:0] mem_addr;
  logic [63:0] mem_rdata = 64'h1111_2222_3333_4444;

  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wide_rd_adapter #(.AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .hsel(hsel), .haddr(haddr), .htrans(htrans),
    .hready(hready), .hrdata(hrdata), .hreadyout(hreadyout), .hresp(hresp),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] half_val(int w, int h);
    return 32'h1000_0000 + w * 2 + h;
  endfunction

  always @(posedge clk)
    if (mem_rd) mem_rdata <= {half_val(int'(mem_addr), 1), half_val(int'(mem_addr), 0)};

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic s, logic r, logic [1:0] t, int a);
    @(negedge clk);
    hsel = s; hready = r; htrans = t; haddr = AW'(a);
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R8 hreadyout", {63'd0, hreadyout}, 64'd1);
    chk("R8 hresp", {63'd0, hresp}, 64'd0);
  end

  task automatic sweep(int step, logic [1:0] t, string req);
    int prev = -1;
    for (int a = 0; a < (1 << AW); a += step) begin
      drive(1, 1, t, a);
      if (prev >= 0) chk(req, {32'd0, hrdata}, {32'd0, 32'h1000_0000 + prev / 4});
      #1;
      chk("R1 index", {56'd0, 3'd0, mem_addr}, 64'(a / 8));
      chk("R2 read", {63'd0, mem_rd}, 64'd1);
      prev = a;
    end
    drive(0, 1, 2'b00, 0);
    chk(req, {32'd0, hrdata}, {32'd0, 32'h1000_0000 + prev / 4});
  endtask

  task automatic hold_case(logic s, logic r, logic [1:0] t, string req);
    drive(1, 1, 2'b10, 12);
    drive(s, r, t, 16);
    #1 chk({req, " no read"}, {63'd0, mem_rd}, 64'd0);
    drive(0, 1, 2'b00, 0);
    chk({req, " hold"}, {32'd0, hrdata}, {32'd0, half_val(1, 1)});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset low half", {32'd0, hrdata}, 64'h3333_4444);
    rst_n = 1;
    @(negedge clk);
    chk("R9 after reset", {32'd0, hrdata}, 64'h3333_4444);
    sweep(1, 2'b10, "R3 R4 every byte");
    sweep(4, 2'b11, "R5 step4");
    drive(1, 1, 2'b10, 0);
    drive(1, 1, 2'b10, 4);
    chk("R3 low half", {32'd0, hrdata}, {32'd0, half_val(0, 0)});
    drive(0, 1, 2'b00, 0);
    chk("R4 high half", {32'd0, hrdata}, {32'd0, half_val(0, 1)});
    hold_case(1, 1, 2'b00, "R6 IDLE");
    hold_case(1, 1, 2'b01, "R6 BUSY");
    hold_case(0, 1, 2'b10, "R7 hsel low");
    hold_case(1, 0, 2'b11, "R7 hready low");
    for (int w = 0; w < NW; w++) begin
      drive(1, 1, 2'b10, w * 8 + 7);
      #1 chk("R1 top byte", {56'd0, 3'd0, mem_addr}, 64'(w));
    end
    drive(0, 1, 2'b00, 0);
    chk("R4 last", {32'd0, hrdata}, {32'd0, half_val(NW - 1, 1)});
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (20000) @(posedge clk); errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion"); end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule